// File: doc/BRIEF.md
# BT.656 Timing Reference Decoder

The block sits on an 8-bit multiplexed 4:2:2 YCbCr byte stream clocked at the byte rate. It watches for the four-byte timing references embedded in the stream and decodes their status bytes into field, vertical-blanking and horizontal flags. Between a start-of-active reference and the following end-of-active reference, it splits the bytes into separate luma and chroma samples. Each sample comes out with its own strobe.

Downstream timing logic receives a pulse at every line boundary, taken at the end-of-active reference, and a pulse whenever the field bit changes. The block also measures the distance between successive references. It checks that distance against the nominal active length and against the blanking length of the standard selected on a pin. A wrong distance, a malformed status byte or two references of the same kind in a row sets a sticky error flag. The flag stays set until reset or a clear pulse.

Top module: `bt656_trc_decoder`

## Requirements
- R1: A reference is the byte sequence 0xFF, 0x00, 0x00 followed by a status byte with bit 7 = 1, where bit 6 is F, bit 5 is V and bit 4 is H. f_o, v_o and h_o take the status bits at the clock edge that samples the status byte. They hold their values until the next accepted reference.
- R2: Status bits 3..0 have no effect on the flags or on the error flag.
- R3: A status byte with bit 7 = 0 is discarded. f_o, v_o and h_o keep their values, and sync_err_o is set.
- R4: H = 0 marks start of active and H = 1 marks end of active. From an end-of-active reference to the next start-of-active reference, the block expects 268 bytes between the two references when std625_i = 0 and 280 bytes when std625_i = 1. Any other count sets sync_err_o.
- R5: From a start-of-active reference to the next end-of-active reference, the block expects 1440 bytes between the two references. Any other count sets sync_err_o. So do two accepted references of the same H kind in a row.
- R6: After a start-of-active reference, the active bytes come out in repeating order Cb, Y, Cr, Y on cb_o/cb_valid_o, y_o/y_valid_o and cr_o/cr_valid_o. Each sample appears one clock after its byte is sampled, and at most one strobe is high at a time. No strobe is raised outside active video, and a 0xFF byte ends active video.
- R7: line_o pulses for one clock with the flag update of each end-of-active reference. field_o pulses for one clock when an accepted reference carries an F value different from the current f_o.
- R8: sync_err_o is sticky. It is cleared by reset or by clr_err_i, and clr_err_i wins over a same-cycle error.
- R9: After reset, all flags, strobes, pulses and sync_err_o are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Byte clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| data_i | input | 8 | Multiplexed YCbCr byte stream |
| std625_i | input | 1 | 1 selects 625-line blanking length, 0 selects 525-line |
| clr_err_i | input | 1 | Clears the sticky error flag |
| f_o | output | 1 | Field flag from last accepted reference |
| v_o | output | 1 | Vertical blanking flag from last accepted reference |
| h_o | output | 1 | Horizontal flag (1 = end of active) |
| line_o | output | 1 | One-clock pulse at each end-of-active reference |
| field_o | output | 1 | One-clock pulse on F change |
| y_o | output | 8 | Luma sample |
| y_valid_o | output | 1 | Luma strobe |
| cb_o | output | 8 | Blue-difference sample |
| cb_valid_o | output | 1 | Cb strobe |
| cr_o | output | 8 | Red-difference sample |
| cr_valid_o | output | 1 | Cr strobe |
| sync_err_o | output | 1 | Sticky sync or length error |

## Verification
The bench aims at blanking lengths one byte short for the selected standard, and at a 625 line presented while the 525 setting is selected. A counter with an off-by-one or a swapped standard select would stay silent on these, or would flag good lines. An active run two bytes short must raise the error only at the following end-of-active reference. A status byte with bit 7 cleared must leave the flags untouched; a design that accepted it would move h_o and f_o. Status bytes with protection bits set, the sticky behaviour across a good line, and a clear pulse that coincides with traffic are also covered. So are the sample order and the absence of strobes in blanking, which a mis-phased demultiplexer would break by swapping Cb and Cr or by leaking preamble bytes.

// File: rtl/bt656_pkg.sv
package bt656_pkg;
  localparam int unsigned CODE_LEN = 4;
  localparam logic [7:0]  PRE_FF   = 8'hFF;
  localparam logic [7:0]  PRE_00   = 8'h00;

  typedef enum logic [1:0] {
    K_CB = 2'd0,
    K_Y0 = 2'd1,
    K_CR = 2'd2,
    K_Y1 = 2'd3
  } smp_kind_e;
endpackage

// File: rtl/trc_detect.sv
module trc_detect
  import bt656_pkg::*;
#(
  parameter int unsigned DW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [DW-1:0] data_i,
  output logic          hit_o,
  output logic          bad_o,
  output logic          stat_h_o,
  output logic          f_o,
  output logic          v_o,
  output logic          h_o,
  output logic          line_o,
  output logic          field_o
);
  logic [DW-1:0] d1_q, d2_q, d3_q;
  logic          pre_seen;

  assign pre_seen = (d3_q == DW'(PRE_FF)) && (d2_q == DW'(PRE_00)) && (d1_q == DW'(PRE_00));
  assign hit_o    = pre_seen && data_i[7];
  assign bad_o    = pre_seen && !data_i[7];
  assign stat_h_o = data_i[4];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      d1_q <= '0;
      d2_q <= '0;
      d3_q <= '0;
    end else begin
      d1_q <= data_i;
      d2_q <= d1_q;
      d3_q <= d2_q;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      f_o     <= 1'b0;
      v_o     <= 1'b0;
      h_o     <= 1'b0;
      line_o  <= 1'b0;
      field_o <= 1'b0;
    end else begin
      line_o  <= hit_o && data_i[4];
      field_o <= hit_o && (data_i[6] != f_o);
      if (hit_o) begin
        f_o <= data_i[6];
        v_o <= data_i[5];
        h_o <= data_i[4];
      end
    end
  end

  p_flags_hold_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !hit_o |=> $stable({f_o, v_o, h_o}));
  p_line_is_eav_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    line_o |-> h_o);
endmodule

// File: rtl/len_check.sv
module len_check
  import bt656_pkg::*;
#(
  parameter int unsigned ACT_LEN = 1440,
  parameter int unsigned BLK_A   = 268,
  parameter int unsigned BLK_B   = 280
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic hit_i,
  input  logic bad_i,
  input  logic stat_h_i,
  input  logic std625_i,
  input  logic clr_i,
  output logic err_o
);
  localparam int unsigned MAXL = (ACT_LEN > BLK_B) ? ACT_LEN : BLK_B;
  localparam int unsigned CW   = $clog2(MAXL + CODE_LEN + 1);
  localparam logic [CW-1:0] EXP_ACT = CW'(ACT_LEN + CODE_LEN - 1);
  localparam logic [CW-1:0] EXP_BA  = CW'(BLK_A + CODE_LEN - 1);
  localparam logic [CW-1:0] EXP_BB  = CW'(BLK_B + CODE_LEN - 1);

  logic [CW-1:0] cnt_q;
  logic          prev_vld_q, prev_h_q;
  logic          len_bad, set_err;

  always_comb begin
    len_bad = 1'b0;
    if (prev_vld_q) begin
      if (stat_h_i == prev_h_q) len_bad = 1'b1;
      else if (stat_h_i)        len_bad = (cnt_q != EXP_ACT);
      else                      len_bad = (cnt_q != (std625_i ? EXP_BB : EXP_BA));
    end
  end

  assign set_err = bad_i || (hit_i && len_bad);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q      <= '0;
      prev_vld_q <= 1'b0;
      prev_h_q   <= 1'b0;
    end else if (hit_i) begin
      cnt_q      <= '0;
      prev_vld_q <= 1'b1;
      prev_h_q   <= stat_h_i;
    end else if (cnt_q != '1) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      err_o <= 1'b0;
    else if (clr_i)   err_o <= 1'b0;
    else if (set_err) err_o <= 1'b1;
  end

  p_err_sticky_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o && !clr_i |=> err_o);
  p_bad_sets_err_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bad_i && !clr_i |=> err_o);
  p_clr_wins_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> !err_o);
endmodule

// File: rtl/sample_demux.sv
module sample_demux
  import bt656_pkg::*;
#(
  parameter int unsigned DW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [DW-1:0] data_i,
  input  logic          sav_i,
  input  logic          eav_i,
  output logic [DW-1:0] y_o,
  output logic          y_valid_o,
  output logic [DW-1:0] cb_o,
  output logic          cb_valid_o,
  output logic [DW-1:0] cr_o,
  output logic          cr_valid_o
);
  logic      in_act_q;
  smp_kind_e ph_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      in_act_q   <= 1'b0;
      ph_q       <= K_CB;
      y_o        <= '0;
      cb_o       <= '0;
      cr_o       <= '0;
      y_valid_o  <= 1'b0;
      cb_valid_o <= 1'b0;
      cr_valid_o <= 1'b0;
    end else begin
      y_valid_o  <= 1'b0;
      cb_valid_o <= 1'b0;
      cr_valid_o <= 1'b0;
      if (sav_i) begin
        in_act_q <= 1'b1;
        ph_q     <= K_CB;
      end else if (eav_i || data_i == {DW{1'b1}}) begin
        in_act_q <= 1'b0;
      end else if (in_act_q) begin
        unique case (ph_q)
          K_CB: begin cb_o <= data_i; cb_valid_o <= 1'b1; end
          K_CR: begin cr_o <= data_i; cr_valid_o <= 1'b1; end
          default: begin y_o <= data_i; y_valid_o <= 1'b1; end
        endcase
        ph_q <= smp_kind_e'(ph_q + 2'd1);
      end
    end
  end

  p_one_strobe_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({y_valid_o, cb_valid_o, cr_valid_o}));
  p_cb_first_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sav_i |=> !y_valid_o && !cr_valid_o);
endmodule

// File: rtl/bt656_trc_decoder.sv
module bt656_trc_decoder #(
  parameter int unsigned DW      = 8,
  parameter int unsigned ACT_LEN = 1440,
  parameter int unsigned BLK_A   = 268,
  parameter int unsigned BLK_B   = 280
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [DW-1:0] data_i,
  input  logic          std625_i,
  input  logic          clr_err_i,
  output logic          f_o,
  output logic          v_o,
  output logic          h_o,
  output logic          line_o,
  output logic          field_o,
  output logic [DW-1:0] y_o,
  output logic          y_valid_o,
  output logic [DW-1:0] cb_o,
  output logic          cb_valid_o,
  output logic [DW-1:0] cr_o,
  output logic          cr_valid_o,
  output logic          sync_err_o
);
  logic hit, bad, stat_h;

  trc_detect #(.DW(DW)) u_det (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .data_i   (data_i),
    .hit_o    (hit),
    .bad_o    (bad),
    .stat_h_o (stat_h),
    .f_o      (f_o),
    .v_o      (v_o),
    .h_o      (h_o),
    .line_o   (line_o),
    .field_o  (field_o)
  );

  len_check #(.ACT_LEN(ACT_LEN), .BLK_A(BLK_A), .BLK_B(BLK_B)) u_len (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .hit_i    (hit),
    .bad_i    (bad),
    .stat_h_i (stat_h),
    .std625_i (std625_i),
    .clr_i    (clr_err_i),
    .err_o    (sync_err_o)
  );

  sample_demux #(.DW(DW)) u_dmx (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .data_i     (data_i),
    .sav_i      (hit && !stat_h),
    .eav_i      (hit && stat_h),
    .y_o        (y_o),
    .y_valid_o  (y_valid_o),
    .cb_o       (cb_o),
    .cb_valid_o (cb_valid_o),
    .cr_o       (cr_o),
    .cr_valid_o (cr_valid_o)
  );

  p_no_strobe_blank_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (y_valid_o || cb_valid_o || cr_valid_o) |-> !h_o);
endmodule

// File: tb/bt656_trc_decoder_test.sv
module bt656_trc_decoder_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] data = 8'h10;
  logic       std625 = 1'b0;
  logic       clr = 1'b0;
  logic       f, v, h, line_p, field_p, yv, cbv, crv, err;
  logic [7:0] y, cb, cr;
  int         checks = 0;
  int         errors = 0;
  bit         done = 1'b0;

  always #2.5 clk = ~clk;

  bt656_trc_decoder uut (
    .clk_i(clk), .rst_ni(rst_n), .data_i(data), .std625_i(std625), .clr_err_i(clr),
    .f_o(f), .v_o(v), .h_o(h), .line_o(line_p), .field_o(field_p),
    .y_o(y), .y_valid_o(yv), .cb_o(cb), .cb_valid_o(cbv), .cr_o(cr), .cr_valid_o(crv),
    .sync_err_o(err)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic drv(input logic [7:0] b, input bit c = 1'b0);
    @(negedge clk);
    data = b;
    clr  = c;
    @(posedge clk);
    #1;
    clr = 1'b0;
  endtask

  function automatic logic [7:0] act_byte(input int i);
    return 8'(1 + ((i * 37) % 253));
  endfunction

  // one line: EAV, blanking, SAV, active
  task automatic send_line(input bit fb, input bit vb, input int blk, input int act,
                           input bit clr_first, input bit exp_field, input logic [3:0] prot);
    int bad_smp = 0;
    drv(8'hFF, clr_first);
    drv(8'h00);
    drv(8'h00);
    drv({1'b1, fb, vb, 1'b1, prot});
    chk(h == 1'b1 && v == vb && f == fb, "R1 eav flags", {f, v, h}, {fb, vb, 1'b1});
    chk(line_p == 1'b1, "R7 line pulse", line_p, 1);
    chk(field_p == exp_field, "R7 field pulse", field_p, exp_field);
    if (yv || cbv || crv) bad_smp++;
    for (int i = 0; i < blk; i++) begin
      drv((i % 2) ? 8'h80 : 8'h10);
      if (yv || cbv || crv) bad_smp++;
      if (i == 0 && line_p) bad_smp++;
    end
    drv(8'hFF);
    if (yv || cbv || crv) bad_smp++;
    drv(8'h00);
    drv(8'h00);
    drv({1'b1, fb, vb, 1'b0, prot});
    chk(h == 1'b0 && line_p == 1'b0, "R1 sav flags", {h, line_p}, 0);
    if (yv || cbv || crv) bad_smp++;
    for (int i = 0; i < act; i++) begin
      drv(act_byte(i));
      case (i % 4)
        0: if (!(cbv && !yv && !crv && cb == act_byte(i))) bad_smp++;
        2: if (!(crv && !yv && !cbv && cr == act_byte(i))) bad_smp++;
        default: if (!(yv && !cbv && !crv && y == act_byte(i))) bad_smp++;
      endcase
    end
    chk(bad_smp == 0, "R6 sample order/strobes", bad_smp, 0);
  endtask

  task automatic t_reset;
    chk({f, v, h, line_p, field_p, yv, cbv, crv, err} == '0, "R9 reset state",
        {f, v, h, line_p, field_p, yv, cbv, crv, err}, 0);
  endtask

  task automatic t_good_525;
    send_line(1'b0, 1'b0, 268, 1440, 1'b0, 1'b0, 4'h0);
    send_line(1'b0, 1'b0, 268, 1440, 1'b0, 1'b0, 4'h0);
    chk(err == 1'b0, "R4 525 good blanking", err, 0);
    send_line(1'b0, 1'b0, 268, 1440, 1'b0, 1'b0, 4'h0);
    chk(err == 1'b0, "R5 good active length", err, 0);
  endtask

  task automatic t_prot_ignored;
    send_line(1'b0, 1'b1, 268, 1440, 1'b0, 1'b0, 4'hA);
    chk(v == 1'b1 && err == 1'b0, "R2 protection bits ignored", {v, err}, 2);
  endtask

  task automatic t_field;
    send_line(1'b1, 1'b0, 268, 1440, 1'b0, 1'b1, 4'h0);
    chk(f == 1'b1, "R7 field now 1", f, 1);
    send_line(1'b1, 1'b0, 268, 1440, 1'b0, 1'b0, 4'h0);
    send_line(1'b0, 1'b0, 268, 1440, 1'b0, 1'b1, 4'h0);
    chk(err == 1'b0, "R5 no error across field change", err, 0);
  endtask

  task automatic t_blank_short;
    send_line(1'b0, 1'b0, 267, 1440, 1'b0, 1'b0, 4'h0);
    chk(err == 1'b1, "R4 short 525 blanking", err, 1);
    send_line(1'b0, 1'b0, 268, 1440, 1'b0, 1'b0, 4'h0);
    chk(err == 1'b1, "R8 error sticky", err, 1);
    send_line(1'b0, 1'b0, 268, 1440, 1'b1, 1'b0, 4'h0);
    chk(err == 1'b0, "R8 clear input", err, 0);
  endtask

  task automatic t_active_short;
    send_line(1'b0, 1'b0, 268, 1438, 1'b0, 1'b0, 4'h0);
    chk(err == 1'b0, "R5 error not before next eav", err, 0);
    send_line(1'b0, 1'b0, 268, 1440, 1'b0, 1'b0, 4'h0);
    chk(err == 1'b1, "R5 short active", err, 1);
    send_line(1'b0, 1'b0, 268, 1440, 1'b1, 1'b0, 4'h0);
    chk(err == 1'b0, "R8 clear after active error", err, 0);
  endtask

  task automatic t_625;
    std625 = 1'b1;
    send_line(1'b0, 1'b0, 280, 1440, 1'b1, 1'b0, 4'h0);
    send_line(1'b0, 1'b0, 280, 1440, 1'b0, 1'b0, 4'h0);
    chk(err == 1'b0, "R4 625 good blanking", err, 0);
    send_line(1'b0, 1'b0, 268, 1440, 1'b0, 1'b0, 4'h0);
    chk(err == 1'b1, "R4 525 blanking under 625", err, 1);
    send_line(1'b0, 1'b0, 280, 1440, 1'b1, 1'b0, 4'h0);
    chk(err == 1'b0, "R8 clear in 625", err, 0);
    std625 = 1'b0;
    send_line(1'b0, 1'b0, 280, 1440, 1'b0, 1'b0, 4'h0);
    chk(err == 1'b1, "R4 625 blanking under 525", err, 1);
    send_line(1'b0, 1'b0, 268, 1440, 1'b1, 1'b0, 4'h0);
    send_line(1'b0, 1'b0, 268, 1440, 1'b0, 1'b0, 4'h0);
    chk(err == 1'b0, "R4 back to 525", err, 0);
  endtask

  task automatic t_bad_status;
    drv(8'hFF);
    drv(8'h00);
    drv(8'h00);
    drv(8'h50);
    chk(h == 1'b0 && f == 1'b0 && line_p == 1'b0, "R3 bad status discarded", {f, h, line_p}, 0);
    chk(err == 1'b1, "R3 bad status error", err, 1);
    drv(8'h10);
    chk(yv == 1'b0 && cbv == 1'b0 && crv == 1'b0, "R6 no strobe after ff", {yv, cbv, crv}, 0);
  endtask

  initial begin
    #(5.0 * 200000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    t_reset();
    @(negedge clk);
    rst_n = 1'b1;
    t_good_525();
    t_prot_ignored();
    t_field();
    t_blank_short();
    t_active_short();
    t_625();
    t_bad_status();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule